// File: doc/BRIEF.md
# Multidrop Address-Filtering Serial Receiver

This block is an asynchronous serial receiver for a shared multidrop line. Each character carries one extra flag bit after its data byte. The flag tells whether the character is a station-address character or an ordinary data character. A wake-up filter, armed by software, throws away data characters silently. It passes on the first address character it sees, and that character disarms the filter in hardware. From then on every character is delivered until software arms the filter again. Software does the comparison of the address against its own station number. After a mismatch, or at the end of a message, it arms the filter again.

The serial line goes through a two-flop synchronizer into a deframing state machine. The machine runs on a 16x oversampling enable. Its states are `ST_IDLE`, `ST_START`, `ST_DATA`, `ST_FLAG` and `ST_STOP`, with these transitions:
- idle to start on a low sample.
- start back to idle when the line is high at mid-bit (a false start).
- start to data when the line is still low at mid-bit.
- data to data for each bit until the last data bit, then data to flag.
- flag to stop.
- stop to idle, which emits the completed character.

A host-side register stage picks one action per completed character: `ACT_NONE`, `ACT_FERR`, `ACT_DROP`, `ACT_OVR` or `ACT_LOAD`. It holds the received byte, the flag bit, the ready flag, the error flags and the filter-arm bit.

Top module: `mp_uart_rx`

## Requirements
- R1: A character is a low start bit, then DATA_W data bits least significant first, then one address flag bit, then a high stop bit. The line idles high. A delivered byte appears on `rx_byte` with the first data bit received in bit 0.
- R2: While `filt_armed` is 1, a character with flag bit 0 is dropped. `rx_avail` and `irq` stay 0, and `rx_byte` keeps its previous value.
- R3: While `filt_armed` is 1, a character with flag bit 1 is loaded and sets `rx_avail`. In the same step `filt_armed` clears to 0.
- R4: While `filt_armed` is 0, every character is loaded whatever its flag bit. `last_flag` shows the flag bit of the most recently loaded character.
- R5: `rx_avail` stays 1 until a one-cycle `rx_ack` pulse clears it.
- R6: A one-cycle `arm_req` pulse sets `filt_armed` to 1. `filt_armed` is 0 after reset.
- R7: A low pulse on the line that has ended by the half-bit point does not start a character. No data is delivered and no error is flagged.
- R8: A stop bit sampled low sets `frame_err`. That character is not loaded and `filt_armed` is left unchanged.
- R9: A character that completes while `rx_avail` is 1 sets `overrun` and does not change `rx_byte`.
- R10: `irq` is 1 exactly when `rx_avail` is 1 and `irq_en` is 1.
- R11: A one-cycle `err_ack` pulse clears both `frame_err` and `overrun`.
- R12: After reset, `rx_byte` is 0. `rx_avail`, `last_flag`, `frame_err`, `overrun`, `filt_armed` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| os_tick | input | 1 | Oversampling enable, 16 pulses per bit time |
| line_in | input | 1 | Serial line, idles high |
| rx_ack | input | 1 | Host pulse: byte taken, clear `rx_avail` |
| arm_req | input | 1 | Software pulse: arm the wake-up filter |
| err_ack | input | 1 | Software pulse: clear both error flags |
| irq_en | input | 1 | Receive interrupt enable |
| rx_byte | output | DATA_W | Last loaded byte |
| rx_avail | output | 1 | Byte ready for the host |
| last_flag | output | 1 | Address flag bit of the last loaded character |
| filt_armed | output | 1 | Wake-up filter armed |
| frame_err | output | 1 | Stop bit was sampled low |
| overrun | output | 1 | Character arrived while a byte was still held |
| irq | output | 1 | Receive interrupt request |

## Verification
The hardest cases to reach from the ports are a character that is dropped silently and a false start. Neither one leaves any trace on the outputs, so the bench has to show that nothing changed. It puts a known byte in place first. It then sends a data character while the filter is armed, and a low glitch five ticks long. After each, it waits a full character time and confirms that `rx_byte` is unchanged, `rx_avail` is low and no error flag is set. The monitor also reports any delivery it did not expect. The overrun and framing-error cases are reached by turning off automatic reading and by sending a character with a low stop bit while the filter is armed.

// File: rtl/mpr_pkg.sv
package mpr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_FLAG,
        ST_STOP
    } rx_state_t;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_FERR,
        ACT_DROP,
        ACT_OVR,
        ACT_LOAD
    } rx_action_t;

endpackage

// File: rtl/mpr_sync.sv
module mpr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= '1;
        end else begin
            pipe <= {pipe[STAGES-2:0], din};
        end
    end

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/mpr_deframer.sv
module mpr_deframer
    import mpr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              line_s,
    output logic              chr_done,
    output logic              chr_stop_ok,
    output logic              chr_flag,
    output logic [DATA_W-1:0] chr_data
);
    localparam int CNT_W  = $clog2(OVS);
    localparam int BIT_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int HALF   = OVS / 2;
    localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(HALF - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(OVS - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

    rx_state_t          state_q, state_d;
    logic [CNT_W-1:0]   os_cnt;
    logic [BIT_W-1:0]   bit_idx;
    logic [DATA_W-1:0]  shreg;
    logic               mid_half;
    logic               mid_full;

    assign mid_half = os_tick && (os_cnt == CNT_HALF);
    assign mid_full = os_tick && (os_cnt == CNT_FULL);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (os_tick && !line_s) state_d = ST_START;
            end
            ST_START: begin
                if (mid_half) state_d = line_s ? ST_IDLE : ST_DATA;
            end
            ST_DATA: begin
                if (mid_full && (bit_idx == BIT_LAST)) state_d = ST_FLAG;
            end
            ST_FLAG: begin
                if (mid_full) state_d = ST_STOP;
            end
            ST_STOP: begin
                if (mid_full) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            os_cnt      <= '0;
            bit_idx     <= '0;
            shreg       <= '0;
            chr_done    <= 1'b0;
            chr_stop_ok <= 1'b0;
            chr_flag    <= 1'b0;
            chr_data    <= '0;
        end else begin
            chr_done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    os_cnt  <= '0;
                    bit_idx <= '0;
                end
                ST_START: begin
                    if (os_tick) begin
                        os_cnt <= mid_half ? '0 : os_cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (os_tick) begin
                        os_cnt <= mid_full ? '0 : os_cnt + 1'b1;
                    end
                    if (mid_full) begin
                        shreg   <= {line_s, shreg[DATA_W-1:1]};
                        bit_idx <= bit_idx + 1'b1;
                    end
                end
                ST_FLAG: begin
                    if (os_tick) begin
                        os_cnt <= mid_full ? '0 : os_cnt + 1'b1;
                    end
                    if (mid_full) chr_flag <= line_s;
                end
                ST_STOP: begin
                    if (os_tick) begin
                        os_cnt <= mid_full ? '0 : os_cnt + 1'b1;
                    end
                    if (mid_full) begin
                        chr_done    <= 1'b1;
                        chr_stop_ok <= line_s;
                        chr_data    <= shreg;
                    end
                end
                default: os_cnt <= '0;
            endcase
        end
    end
endmodule

// File: rtl/mpr_hostregs.sv
module mpr_hostregs
    import mpr_pkg::*;
#(
    parameter int   DATA_W    = 8,
    parameter logic ARM_RESET = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chr_done,
    input  logic              chr_stop_ok,
    input  logic              chr_flag,
    input  logic [DATA_W-1:0] chr_data,
    input  logic              rx_ack,
    input  logic              arm_req,
    input  logic              err_ack,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_avail,
    output logic              last_flag,
    output logic              filt_armed,
    output logic              frame_err,
    output logic              overrun
);
    rx_action_t act;
    logic       avail_eff;

    // a same-cycle acknowledge frees the holding register
    assign avail_eff = rx_avail && !rx_ack;

    always_comb begin
        act = ACT_NONE;
        if (chr_done) begin
            if (!chr_stop_ok)                act = ACT_FERR;
            else if (filt_armed && !chr_flag) act = ACT_DROP;
            else if (avail_eff)              act = ACT_OVR;
            else                             act = ACT_LOAD;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_byte    <= '0;
            rx_avail   <= 1'b0;
            last_flag  <= 1'b0;
            filt_armed <= ARM_RESET;
            frame_err  <= 1'b0;
            overrun    <= 1'b0;
        end else begin
            if (rx_ack)  rx_avail <= 1'b0;
            if (err_ack) begin
                frame_err <= 1'b0;
                overrun   <= 1'b0;
            end
            unique case (act)
                ACT_NONE: ;
                ACT_FERR: frame_err <= 1'b1;
                ACT_DROP: ;
                ACT_OVR:  overrun <= 1'b1;
                ACT_LOAD: begin
                    rx_byte   <= chr_data;
                    last_flag <= chr_flag;
                    rx_avail  <= 1'b1;
                    if (filt_armed) filt_armed <= 1'b0;
                end
                default: ;
            endcase
            // software arming takes precedence over the hardware clear
            if (arm_req) filt_armed <= 1'b1;
        end
    end
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx #(
    parameter int   DATA_W    = 8,
    parameter int   OVS       = 16,
    parameter int   SYNC_LEN  = 2,
    parameter logic ARM_RESET = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              line_in,
    input  logic              rx_ack,
    input  logic              arm_req,
    input  logic              err_ack,
    input  logic              irq_en,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_avail,
    output logic              last_flag,
    output logic              filt_armed,
    output logic              frame_err,
    output logic              overrun,
    output logic              irq
);
    logic              line_s;
    logic              chr_done;
    logic              chr_stop_ok;
    logic              chr_flag;
    logic [DATA_W-1:0] chr_data;

    mpr_sync #(.STAGES(SYNC_LEN)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (line_in),
        .dout (line_s)
    );

    mpr_deframer #(.DATA_W(DATA_W), .OVS(OVS)) defr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .os_tick    (os_tick),
        .line_s     (line_s),
        .chr_done   (chr_done),
        .chr_stop_ok(chr_stop_ok),
        .chr_flag   (chr_flag),
        .chr_data   (chr_data)
    );

    mpr_hostregs #(.DATA_W(DATA_W), .ARM_RESET(ARM_RESET)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .chr_done   (chr_done),
        .chr_stop_ok(chr_stop_ok),
        .chr_flag   (chr_flag),
        .chr_data   (chr_data),
        .rx_ack     (rx_ack),
        .arm_req    (arm_req),
        .err_ack    (err_ack),
        .rx_byte    (rx_byte),
        .rx_avail   (rx_avail),
        .last_flag  (last_flag),
        .filt_armed (filt_armed),
        .frame_err  (frame_err),
        .overrun    (overrun)
    );

    assign irq = rx_avail && irq_en;
endmodule

// File: rtl/mpr_checker.sv
module mpr_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_ack,
    input logic              irq_en,
    input logic [DATA_W-1:0] rx_byte,
    input logic              rx_avail,
    input logic              last_flag,
    input logic              filt_armed,
    input logic              frame_err,
    input logic              irq
);
    // R2: anything loaded while armed must have been an address character
    assert_armed_load_is_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rx_avail) && $past(filt_armed)) |-> last_flag);

    // R3: the filter only disarms on a loaded address character
    assert_disarm_on_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(filt_armed) |-> (rx_avail && last_flag));

    // R5: ready holds without an acknowledge
    assert_avail_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_avail && !rx_ack) |=> rx_avail);

    // R9: a held byte is never overwritten
    assert_no_overwrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_avail && !rx_ack) |=> $stable(rx_byte));

    // R8: a framing error never coincides with a load
    assert_ferr_no_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_err) |-> !$rose(rx_avail));

    // R10: interrupt needs enable and a waiting byte
    assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);
    assert_irq_needs_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> rx_avail);
endmodule

bind mp_uart_rx mpr_checker #(.DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_ack    (rx_ack),
    .irq_en    (irq_en),
    .rx_byte   (rx_byte),
    .rx_avail  (rx_avail),
    .last_flag (last_flag),
    .filt_armed(filt_armed),
    .frame_err (frame_err),
    .irq       (irq)
);

// File: tb/mp_uart_rx_tb_top.sv
`timescale 1ns/1ps
module mp_uart_rx_tb_top;
    localparam int DATA_W   = 8;
    localparam int OVS      = 16;
    localparam int TICK_DIV = 4;
    localparam int BIT_CYC  = OVS * TICK_DIV;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              os_tick = 1'b0;
    logic              line_in = 1'b1;
    logic              rx_ack = 1'b0;
    logic              arm_req = 1'b0;
    logic              err_ack = 1'b0;
    logic              irq_en = 1'b0;
    logic [DATA_W-1:0] rx_byte;
    logic              rx_avail, last_flag, filt_armed, frame_err, overrun, irq;

    int total = 0;
    int bad = 0;
    logic auto_read = 1'b0;
    logic [DATA_W:0] exp_q[$];

    always #5 clk = ~clk;

    mp_uart_rx #(.DATA_W(DATA_W), .OVS(OVS)) dut_i (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .line_in(line_in),
        .rx_ack(rx_ack), .arm_req(arm_req), .err_ack(err_ack), .irq_en(irq_en),
        .rx_byte(rx_byte), .rx_avail(rx_avail), .last_flag(last_flag),
        .filt_armed(filt_armed), .frame_err(frame_err), .overrun(overrun), .irq(irq)
    );

    // oversampling enable
    initial begin
        forever begin
            for (int i = 0; i < TICK_DIV; i++) begin
                @(negedge clk);
                os_tick = (i == TICK_DIV - 1);
            end
        end
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        line_in = b;
        repeat (BIT_CYC) @(negedge clk);
    endtask

    // driver: sends a character and queues it when a load is expected
    task automatic send_chr(input logic [DATA_W-1:0] d, input logic flag,
                            input logic stop, input logic expect_load);
        if (expect_load) exp_q.push_back({flag, d});
        send_bit(1'b0);
        for (int i = 0; i < DATA_W; i++) send_bit(d[i]);
        send_bit(flag);
        send_bit(stop);
        line_in = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk); sig = 1'b1;
        @(negedge clk); sig = 1'b0;
    endtask

    // monitor: pops and compares every load while auto reading
    initial begin
        forever begin
            @(negedge clk);
            if (auto_read && rx_avail) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected load", {last_flag, rx_byte}, 0);
                end else begin
                    logic [DATA_W:0] e;
                    e = exp_q.pop_front();
                    check(rx_byte == e[DATA_W-1:0], "R1 byte", rx_byte, e[DATA_W-1:0]);
                    check(last_flag == e[DATA_W], "R4 flag", last_flag, e[DATA_W]);
                end
                rx_ack = 1'b1;
                @(negedge clk);
                rx_ack = 1'b0;
            end
        end
    end

    // watchdog
    initial begin
        repeat (190000) @(negedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check(rx_byte == 0 && !rx_avail && !last_flag, "R12 data regs", {last_flag, rx_avail, rx_byte}, 0);
        check(!filt_armed && !frame_err && !overrun && !irq, "R12 flags",
              {filt_armed, frame_err, overrun, irq}, 0);

        // R4: disarmed, all characters loaded
        irq_en = 1'b1;
        auto_read = 1'b1;
        send_chr(8'hA5, 1'b0, 1'b1, 1'b1);
        send_chr(8'h3C, 1'b1, 1'b1, 1'b1);
        send_chr(8'h01, 1'b0, 1'b1, 1'b1);
        check(exp_q.size() == 0, "R4 all delivered", exp_q.size(), 0);

        // R6: arm
        pulse(arm_req);
        @(negedge clk);
        check(filt_armed == 1'b1, "R6 armed", filt_armed, 1);

        // R2: data character dropped while armed
        send_chr(8'h11, 1'b0, 1'b1, 1'b0);
        repeat (20) @(negedge clk);
        check(!rx_avail && rx_byte == 8'h01, "R2 dropped", rx_byte, 8'h01);
        check(filt_armed == 1'b1, "R2 still armed", filt_armed, 1);

        // R3: address character loads and disarms
        send_chr(8'h42, 1'b1, 1'b1, 1'b1);
        check(filt_armed == 1'b0, "R3 disarmed", filt_armed, 0);
        send_chr(8'h77, 1'b0, 1'b1, 1'b1);
        check(exp_q.size() == 0, "R3 follow-on data", exp_q.size(), 0);

        // R10, R5, R9: manual reads
        auto_read = 1'b0;
        irq_en = 1'b0;
        send_chr(8'h5A, 1'b0, 1'b1, 1'b0);
        check(rx_avail && !irq, "R10 masked", irq, 0);
        irq_en = 1'b1;
        @(negedge clk);
        check(irq == 1'b1, "R10 enabled", irq, 1);
        repeat (100) @(negedge clk);
        check(rx_avail == 1'b1, "R5 holds", rx_avail, 1);
        send_chr(8'h99, 1'b0, 1'b1, 1'b0);
        check(overrun == 1'b1, "R9 overrun", overrun, 1);
        check(rx_byte == 8'h5A, "R9 held byte", rx_byte, 8'h5A);
        pulse(rx_ack);
        @(negedge clk);
        check(!rx_avail && !irq, "R5 cleared", rx_avail, 0);
        pulse(err_ack);
        @(negedge clk);
        check(!overrun, "R11 overrun cleared", overrun, 0);

        // R8: framing error while armed
        auto_read = 1'b1;
        pulse(arm_req);
        send_chr(8'h24, 1'b1, 1'b0, 1'b0);
        repeat (20) @(negedge clk);
        check(frame_err == 1'b1, "R8 ferr set", frame_err, 1);
        check(filt_armed == 1'b1 && !rx_avail, "R8 not loaded", filt_armed, 1);
        pulse(err_ack);
        @(negedge clk);
        check(!frame_err, "R11 ferr cleared", frame_err, 0);

        // R7: short low glitch ignored
        line_in = 1'b0;
        repeat (5 * TICK_DIV) @(negedge clk);
        line_in = 1'b1;
        repeat (12 * BIT_CYC) @(negedge clk);
        check(!rx_avail && !frame_err && rx_byte == 8'h5A, "R7 glitch ignored", rx_byte, 8'h5A);
        check(filt_armed == 1'b1, "R7 still armed", filt_armed, 1);
        send_chr(8'h81, 1'b1, 1'b1, 1'b1);
        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R7 clean after glitch", exp_q.size(), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule